// File: doc/BRIEF.md
# Parallel SAR Converter Host Sequencer

This block is the synchronous master for a 16-bit successive-approximation converter with a byte-wide parallel bus. A request carries two choices: the power mode the converter should enter after it converts, and whether the result is returned in two's complement. The block then runs one complete conversion cycle on the converter pins. It makes three falling edges on the active-low select line. The read/convert line carries a different meaning at each edge: it opens the acquisition, it starts the conversion and picks the power mode, and it requests the read.

The sequencer waits for the converter's active-low end-of-conversion flag, which it first passes through a synchronizer. It then reads the low byte and the high byte with the byte-select line and returns the assembled word on a valid/ready result port. When the previous cycle left the reference powered down, the acquisition window is stretched to the reference wake-up time. Every timing minimum is a parameter in nanoseconds, and the block rounds each one up to whole clock cycles of the CLK_PERIOD_NS parameter.

Top module: `sar_host_ctrl`

## Requirements
- R1: While reset is held and right after it is released: the select line is high, read/convert is low, the byte-select line is low, no result is valid, and the request port is ready.
- R2: Each cycle makes its select-line falling edges in a fixed order. At the first edge read/convert is 0. At the second edge read/convert equals the requested mode, where 1 means power down after the conversion and 0 means stay in standby. At the third edge read/convert is 1.
- R3: When the reference is on, the first and second falling edges are at least ceil(ACQ_NS/CLK_PERIOD_NS) cycles apart.
- R4: After reset, after a cycle that requested power-down and after a timed-out cycle, the first-to-second edge interval is at least ceil(WAKE_NS/CLK_PERIOD_NS) cycles. After a standby cycle the interval is shorter than that.
- R5: Read/convert is stable for at least the setup cycles before every select fall and for at least the hold cycles after it. Every high and every low pulse of the select line lasts at least the pulse-width cycles.
- R6: The third falling edge occurs only while the end-of-conversion input is low.
- R7: The low byte is taken with byte-select 0 and the high byte with byte-select 1. Each byte is sampled at least the data-delay cycles after the select fall or the byte-select change, and the word is {high, low}.
- R8: With the two's-complement choice set, bit 15 of the word is inverted. Without it the word is returned unchanged.
- R9: After the read, the select line stays high for at least the bus-relinquish cycles before the next first edge.
- R10: If end-of-conversion is not seen low within ceil(EOC_TIMEOUT_NS/CLK_PERIOD_NS)+SYNC_STAGES cycles of the conversion wait, no third edge is made. The result then has the timeout flag set and data 0.
- R11: A result stays valid with stable data and flag until it is taken with res_ready. The request port is not ready while a cycle or a pending result is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_shdn | input | 1 | 1: power down after conversion, 0: standby |
| req_twos | input | 1 | 1: return result in two's complement |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result taken |
| res_data | output | 16 | Converted word |
| res_timeout | output | 1 | End of conversion never seen |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_rc | output | 1 | Read/convert level |
| adc_hben | output | 1 | Byte select, 1 = high byte |
| adc_done_n | input | 1 | End of conversion, asynchronous, falls when done |
| adc_bus | input | 8 | Converter data byte |

## Verification
The assertions assume two things about the converter. Its end-of-conversion flag falls only after the second edge, and it rises again only once the read has released the select line. The byte bus must also be steady for as long as select and byte-select are steady past the data delay. The bench drives the pins from a converter model that follows these rules: it delays its data by the data-delay count and returns a marker byte before that, so an early sample shows up as a data mismatch. For the timeout case the model keeps its flag high for the whole cycle. Its state is then cleared before the next request, so no later edge sees a stale flag.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACQ_LOW,
        ST_ACQ,
        ST_CNV_LOW,
        ST_EOC_WAIT,
        ST_RD_LO,
        ST_RD_HI,
        ST_RELQ,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic shdn;
        logic twos;
        logic wake;
        logic tout;
    } cyc_ctx_t;

    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sar_host_sync.sv
module sar_host_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/sar_host_word.sv
module sar_host_word #(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                cap_lo,
    input  logic                cap_hi,
    input  logic                twos_en,
    input  logic [DATA_W/2-1:0] bus,
    output logic [DATA_W-1:0]   word
);
    localparam int BYTE_W = DATA_W / 2;

    logic [BYTE_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= bus;
            if (cap_hi) hi_q <= bus;
        end
    end

    assign word = {hi_q, lo_q} ^ {twos_en, {(DATA_W-1){1'b0}}};
endmodule

// File: rtl/sar_host_seq.sv
module sar_host_seq
    import sar_host_pkg::*;
#(
    parameter int CNT_W      = 22,
    parameter int SET_C      = 10,
    parameter int LOW_C      = 10,
    parameter int ACQ_GAP_C  = 100,
    parameter int WAKE_GAP_C = 1000,
    parameter int EOCW_MIN_C = 10,
    parameter int TO_C       = 1200,
    parameter int RD1_C      = 10,
    parameter int DO_C       = 10,
    parameter int RELQ_C     = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_shdn,
    input  logic req_twos,
    output logic req_ready,
    input  logic res_ready,
    output logic res_valid,
    output logic res_timeout,
    input  logic done_n,
    output logic cs_n,
    output logic rc,
    output logic hben,
    output logic cap_lo,
    output logic cap_hi,
    output logic clr_word,
    output logic twos_en
);
    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  elapsed_q;
    logic [CNT_W-1:0]  dur;
    logic              last;
    logic              eoc_ok;
    logic              ref_off_q;
    cyc_ctx_t          ctx_q;

    always_comb begin
        case (state_q)
            ST_SETUP:               dur = CNT_W'(SET_C);
            ST_ACQ_LOW, ST_CNV_LOW: dur = CNT_W'(LOW_C);
            ST_ACQ:                 dur = ctx_q.wake ? CNT_W'(WAKE_GAP_C) : CNT_W'(ACQ_GAP_C);
            ST_EOC_WAIT:            dur = CNT_W'(TO_C);
            ST_RD_LO:               dur = CNT_W'(RD1_C);
            ST_RD_HI:               dur = CNT_W'(DO_C);
            ST_RELQ:                dur = CNT_W'(RELQ_C);
            default:                dur = CNT_W'(1);
        endcase
    end

    assign last   = (elapsed_q == dur - CNT_W'(1));
    assign eoc_ok = !done_n && (elapsed_q >= CNT_W'(EOCW_MIN_C - 1));

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_SETUP;
            ST_SETUP:    if (last) state_d = ST_ACQ_LOW;
            ST_ACQ_LOW:  if (last) state_d = ST_ACQ;
            ST_ACQ:      if (last) state_d = ST_CNV_LOW;
            ST_CNV_LOW:  if (last) state_d = ST_EOC_WAIT;
            ST_EOC_WAIT: begin
                if (eoc_ok)    state_d = ST_RD_LO;
                else if (last) state_d = ST_RELQ;
            end
            ST_RD_LO:    if (last) state_d = ST_RD_HI;
            ST_RD_HI:    if (last) state_d = ST_RELQ;
            ST_RELQ:     if (last) state_d = ST_DONE;
            ST_DONE:     if (res_ready) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            elapsed_q <= '0;
            ref_off_q <= 1'b1;
            ctx_q     <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || state_q == ST_IDLE || state_q == ST_DONE)
                elapsed_q <= '0;
            else
                elapsed_q <= elapsed_q + CNT_W'(1);
            if (state_q == ST_IDLE && req_valid) begin
                ctx_q.shdn <= req_shdn;
                ctx_q.twos <= req_twos;
                ctx_q.wake <= ref_off_q;
                ctx_q.tout <= 1'b0;
            end
            if (state_q == ST_EOC_WAIT && !eoc_ok && last)
                ctx_q.tout <= 1'b1;
            if (state_q == ST_RELQ && last)
                ref_off_q <= ctx_q.tout | ctx_q.shdn;
        end
    end

    always_comb begin
        cs_n = 1'b1;
        rc   = 1'b0;
        hben = 1'b0;
        case (state_q)
            ST_ACQ_LOW:  cs_n = 1'b0;
            ST_ACQ:      rc   = ctx_q.shdn;
            ST_CNV_LOW:  begin cs_n = 1'b0; rc = ctx_q.shdn; end
            ST_EOC_WAIT: rc   = 1'b1;
            ST_RD_LO:    begin cs_n = 1'b0; rc = 1'b1; end
            ST_RD_HI:    begin cs_n = 1'b0; rc = 1'b1; hben = 1'b1; end
            default:     ;
        endcase
    end

    assign cap_lo      = (state_q == ST_RD_LO) && last;
    assign cap_hi      = (state_q == ST_RD_HI) && last;
    assign clr_word    = (state_q == ST_IDLE) && req_valid;
    assign twos_en     = ctx_q.twos & ~ctx_q.tout;
    assign req_ready   = (state_q == ST_IDLE);
    assign res_valid   = (state_q == ST_DONE);
    assign res_timeout = ctx_q.tout;
endmodule

// File: rtl/sar_host_ctrl.sv
module sar_host_ctrl
    import sar_host_pkg::*;
#(
    parameter int CLK_PERIOD_NS  = 4,
    parameter int ACQ_NS         = 2000,
    parameter int WAKE_NS        = 12000000,
    parameter int SETUP_NS       = 40,
    parameter int HOLD_NS        = 40,
    parameter int CS_PULSE_NS    = 40,
    parameter int DATA_DELAY_NS  = 40,
    parameter int RELINQUISH_NS  = 40,
    parameter int EOC_TIMEOUT_NS = 4700,
    parameter int SYNC_STAGES    = 2,
    parameter int DATA_W         = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_shdn,
    input  logic              req_twos,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DATA_W-1:0] res_data,
    output logic              res_timeout,
    output logic              adc_cs_n,
    output logic              adc_rc,
    output logic              adc_hben,
    input  logic              adc_done_n,
    input  logic [DATA_W/2-1:0] adc_bus
);
    localparam int SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_PERIOD_NS);
    localparam int HOLD_CYC  = ns_to_cyc(HOLD_NS, CLK_PERIOD_NS);
    localparam int CSW_CYC   = ns_to_cyc(CS_PULSE_NS, CLK_PERIOD_NS);
    localparam int DO_CYC    = ns_to_cyc(DATA_DELAY_NS, CLK_PERIOD_NS);
    localparam int BR_CYC    = ns_to_cyc(RELINQUISH_NS, CLK_PERIOD_NS);
    localparam int ACQ_CYC   = ns_to_cyc(ACQ_NS, CLK_PERIOD_NS);
    localparam int WAKE_CYC  = ns_to_cyc(WAKE_NS, CLK_PERIOD_NS);
    localparam int LOW_CYC   = imax(CSW_CYC, HOLD_CYC);
    localparam int SET_CYC   = imax(SETUP_CYC, CSW_CYC);
    localparam int ACQ_GAP   = imax(imax(ACQ_CYC - LOW_CYC, SETUP_CYC), CSW_CYC);
    localparam int WAKE_GAP  = imax(imax(WAKE_CYC - LOW_CYC, SETUP_CYC), CSW_CYC);
    localparam int EOCW_MIN  = imax(SETUP_CYC, CSW_CYC);
    localparam int TO_CYC    = ns_to_cyc(EOC_TIMEOUT_NS, CLK_PERIOD_NS) + SYNC_STAGES;
    localparam int RD1_CYC   = imax(DO_CYC, LOW_CYC);
    localparam int RELQ_CYC  = imax(BR_CYC, CSW_CYC);
    localparam int CNT_W     = $clog2(imax(imax(WAKE_GAP, TO_CYC), ACQ_GAP) + 2);

    logic done_n_s;
    logic cap_lo, cap_hi, clr_word, twos_en;

    sar_host_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (adc_done_n),
        .sync_out (done_n_s)
    );

    sar_host_seq #(
        .CNT_W      (CNT_W),
        .SET_C      (SET_CYC),
        .LOW_C      (LOW_CYC),
        .ACQ_GAP_C  (ACQ_GAP),
        .WAKE_GAP_C (WAKE_GAP),
        .EOCW_MIN_C (EOCW_MIN),
        .TO_C       (TO_CYC),
        .RD1_C      (RD1_CYC),
        .DO_C       (DO_CYC),
        .RELQ_C     (RELQ_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_shdn    (req_shdn),
        .req_twos    (req_twos),
        .req_ready   (req_ready),
        .res_ready   (res_ready),
        .res_valid   (res_valid),
        .res_timeout (res_timeout),
        .done_n      (done_n_s),
        .cs_n        (adc_cs_n),
        .rc          (adc_rc),
        .hben        (adc_hben),
        .cap_lo      (cap_lo),
        .cap_hi      (cap_hi),
        .clr_word    (clr_word),
        .twos_en     (twos_en)
    );

    sar_host_word #(.DATA_W(DATA_W)) u_word (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_word),
        .cap_lo  (cap_lo),
        .cap_hi  (cap_hi),
        .twos_en (twos_en),
        .bus     (adc_bus),
        .word    (res_data)
    );
endmodule

// File: rtl/sar_host_chk.sv
module sar_host_chk #(
    parameter int MIN_LOW = 1,
    parameter int DATA_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_cs_n,
    input logic              adc_rc,
    input logic              adc_hben,
    input logic              res_valid,
    input logic              res_ready,
    input logic [DATA_W-1:0] res_data,
    input logic              res_timeout
);
    logic [15:0] low_len;

    always_ff @(posedge clk) begin
        if (rst || adc_cs_n) low_len <= '0;
        else if (low_len != 16'hFFFF) low_len <= low_len + 16'd1;
    end

    AST_RC_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(adc_rc)); // R5

    AST_CS_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs_n) |-> (int'(low_len) >= MIN_LOW)); // R5

    AST_HBEN_SELECTED: assert property (@(posedge clk) disable iff (rst)
        adc_hben |-> !adc_cs_n); // R7

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_timeout))); // R11

    AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_timeout) |-> (res_data == '0)); // R10

    AST_RESULT_RELEASED: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> adc_cs_n); // R9
endmodule

bind sar_host_ctrl sar_host_chk #(.MIN_LOW(CSW_CYC), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .adc_cs_n    (adc_cs_n),
    .adc_rc      (adc_rc),
    .adc_hben    (adc_hben),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_data    (res_data),
    .res_timeout (res_timeout)
);

// File: tb/test_sar_host_ctrl.sv
module test_sar_host_ctrl;
    localparam int P       = 4;
    localparam int ACQ_NS  = 400;
    localparam int WAKE_NS = 4000;
    localparam int SU_NS   = 40;
    localparam int HO_NS   = 20;
    localparam int PW_NS   = 60;
    localparam int DD_NS   = 32;
    localparam int BR_NS   = 48;
    localparam int TO_NS   = 1200;
    localparam int SYNC    = 2;
    localparam int ACQ_B   = (ACQ_NS + P - 1) / P;
    localparam int WAKE_B  = (WAKE_NS + P - 1) / P;
    localparam int SET_B   = (SU_NS + P - 1) / P;
    localparam int HOLD_B  = (HO_NS + P - 1) / P;
    localparam int CSW_B   = (PW_NS + P - 1) / P;
    localparam int DO_B    = (DD_NS + P - 1) / P;
    localparam int BR_B    = (BR_NS + P - 1) / P;
    localparam int TO_B    = (TO_NS + P - 1) / P + SYNC;
    localparam int CONV_B  = 150;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_shdn = 1'b0, req_twos = 1'b0, res_ready = 1'b0;
    logic        req_ready, res_valid, res_timeout;
    logic [15:0] res_data;
    logic        adc_cs_n, adc_rc, adc_hben;
    logic        adc_done_n = 1'b1;
    logic [7:0]  adc_bus = 8'h5A;

    always #2 clk = ~clk;

    sar_host_ctrl #(
        .CLK_PERIOD_NS(P), .ACQ_NS(ACQ_NS), .WAKE_NS(WAKE_NS), .SETUP_NS(SU_NS),
        .HOLD_NS(HO_NS), .CS_PULSE_NS(PW_NS), .DATA_DELAY_NS(DD_NS),
        .RELINQUISH_NS(BR_NS), .EOC_TIMEOUT_NS(TO_NS), .SYNC_STAGES(SYNC), .DATA_W(16)
    ) i_sar_host_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_shdn(req_shdn), .req_twos(req_twos), .res_valid(res_valid),
        .res_ready(res_ready), .res_data(res_data), .res_timeout(res_timeout),
        .adc_cs_n(adc_cs_n), .adc_rc(adc_rc), .adc_hben(adc_hben),
        .adc_done_n(adc_done_n), .adc_bus(adc_bus)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // converter model and pin monitor
    logic [15:0] mdl_word = 16'h0;
    bit  stuck = 0, mdl_clear = 0;
    int  cyc = 0, phase = 0, nfalls = 0;
    int  t_fall[3];
    bit  rc_at[3];
    bit  eoc_at3 = 1;
    int  fall_cyc = -1000000, last_rise = -1000000, br_gap = 1000000;
    int  cs_age = 1000, rc_age = 1000, rd_cnt = 0, conv_left = 0;
    bit  conv_on = 0;
    int  viol_setup = 0, viol_hold = 0, viol_csw = 0;
    logic prev_cs = 1'b1, prev_rc = 1'b0, prev_hb = 1'b0;

    always @(negedge clk) begin
        bit fell, rose, rcc, hbc;
        cyc = cyc + 1;
        if (mdl_clear) begin phase = 0; conv_on = 0; end
        fell = prev_cs && !adc_cs_n;
        rose = !prev_cs && adc_cs_n;
        rcc  = (adc_rc != prev_rc);
        hbc  = (adc_hben != prev_hb);
        if (!rst) begin
            if (fell) begin
                if (cs_age < CSW_B) viol_csw++;
                if (rcc || rc_age < SET_B) viol_setup++;
                fall_cyc = cyc;
                case (phase)
                    0: begin rc_at[0] = adc_rc; t_fall[0] = cyc; br_gap = cyc - last_rise;
                             nfalls = 1; phase = 1; end
                    1: begin rc_at[1] = adc_rc; t_fall[1] = cyc; nfalls = 2;
                             conv_on = 1; conv_left = CONV_B; phase = 2; end
                    2: begin rc_at[2] = adc_rc; eoc_at3 = adc_done_n; nfalls = 3; phase = 3; end
                    default: nfalls++;
                endcase
            end
            if (rose) begin
                if (cs_age < CSW_B) viol_csw++;
                if (phase == 3) begin last_rise = cyc; adc_done_n = 1'b1; phase = 0; end
            end
            if (rcc && (cyc - fall_cyc) < HOLD_B) viol_hold++;
        end
        cs_age = (fell || rose) ? 1 : cs_age + 1;
        rc_age = rcc ? 1 : rc_age + 1;
        rd_cnt = (fell || hbc) ? 1 : rd_cnt + 1;
        if (conv_on) begin
            conv_left--;
            if (conv_left <= 0) begin
                conv_on = 0;
                if (!stuck) adc_done_n = 1'b0;
            end
        end
        adc_bus = (!adc_cs_n && phase == 3 && rd_cnt >= DO_B) ?
                  (adc_hben ? mdl_word[15:8] : mdl_word[7:0]) : 8'h5A;
        prev_cs = adc_cs_n;
        prev_rc = adc_rc;
        prev_hb = adc_hben;
    end

    bit wake_exp = 1;

    task automatic run_conv(input logic [15:0] val, input bit shdn, input bit twos,
                            input int stall, input bit exp_to);
        logic [15:0] exp_data, got;
        int iv, vcyc;
        mdl_word = val;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_shdn = shdn; req_twos = twos;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R11 busy not ready", int'(req_ready), 0);
        while (!res_valid) @(negedge clk);
        vcyc = cyc;
        got = res_data;
        exp_data = exp_to ? 16'h0 : (val ^ {twos, 15'h0});
        chk(res_data == exp_data, twos ? "R8 twos word" : "R7 word assembly", int'(res_data), int'(exp_data));
        chk(res_timeout == exp_to, "R10 timeout flag", int'(res_timeout), int'(exp_to));
        chk(nfalls == (exp_to ? 2 : 3), exp_to ? "R10 no read edge" : "R2 edge count", nfalls, exp_to ? 2 : 3);
        chk(rc_at[0] == 1'b0, "R2 first edge rc", int'(rc_at[0]), 0);
        chk(rc_at[1] == shdn, "R2 second edge rc", int'(rc_at[1]), int'(shdn));
        iv = t_fall[1] - t_fall[0];
        if (wake_exp) chk(iv >= WAKE_B, "R4 wake interval", iv, WAKE_B);
        else begin
            chk(iv >= ACQ_B, "R3 acquisition interval", iv, ACQ_B);
            chk(iv < WAKE_B, "R4 no wake after standby", iv, WAKE_B);
        end
        if (!exp_to) begin
            chk(rc_at[2] == 1'b1, "R2 third edge rc", int'(rc_at[2]), 1);
            chk(eoc_at3 == 1'b0, "R6 read after eoc", int'(eoc_at3), 0);
        end else begin
            chk((vcyc - t_fall[1]) >= TO_B, "R10 timeout window", vcyc - t_fall[1], TO_B);
        end
        chk(br_gap >= BR_B, "R9 relinquish gap", br_gap, BR_B);
        chk(viol_setup == 0 && viol_hold == 0, "R5 rc setup/hold", viol_setup + viol_hold, 0);
        chk(viol_csw == 0, "R5 select pulse width", viol_csw, 0);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(res_valid && res_data == got && !req_ready, "R11 held result", int'(res_data), int'(got));
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk(!res_valid, "R11 result taken", int'(res_valid), 0);
        wake_exp = exp_to ? 1'b1 : shdn;
    endtask

    function automatic logic [15:0] pat(input int m, input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h8000;
            3: return 16'h7FFF;
            default: return 16'((k * 16'h3B29) ^ (m * 16'h1111) ^ 16'h0101);
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(adc_cs_n == 1'b1 && adc_rc == 1'b0 && adc_hben == 1'b0, "R1 pins in reset",
            int'({adc_cs_n, adc_rc, adc_hben}), 4);
        chk(!res_valid && req_ready, "R1 ports in reset", int'({res_valid, req_ready}), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(adc_cs_n == 1'b1 && !res_valid && req_ready, "R1 after release",
            int'({adc_cs_n, res_valid, req_ready}), 5);
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 7; k++)
                run_conv(pat(m, k), m[0], m[1], (k == 2) ? 5 : 0, 1'b0);
        // timeout, then recovery with wake wait
        stuck = 1;
        run_conv(16'h1234, 1'b0, 1'b1, 3, 1'b1);
        stuck = 0;
        mdl_clear = 1;
        @(negedge clk);
        @(negedge clk);
        mdl_clear = 0;
        run_conv(16'hC3A1, 1'b0, 1'b0, 0, 1'b0);
        run_conv(16'h0F1E, 1'b0, 1'b1, 0, 1'b0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule